// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies an M×K matrix by a K×N matrix on a fixed grid of multiply-accumulate cells, where M and N are at most the grid height and width. Each cell keeps its own running sum in place. The left operand enters one column per cycle, one element per grid row, at the left edge. It moves one cell to the right on each clock. The right operand enters one row per cycle, one element per grid column, at the top edge. It moves one cell down on each clock. Edge delay lines stagger the rows and columns so that the two elements sharing an inner index meet in the same cell on the same cycle.

A job begins with a start pulse, which latches M, N and K and clears every sum. The block then takes exactly K operand beats through a valid/ready port. After the last operand has passed the farthest active cell, the block raises a done flag. It then presents the M result rows one at a time on a valid/ready output port. Each input word enters the grid once and each result row leaves it once.

Top module: `sys_matmul`

## Requirements
- R1: After a job, output row r, column j carries the sum over the inner index of A[r][k]·B[k][j], with 8-bit operands treated as two's complement. The result is presented sign-extended in an AW-bit field at bit offset j·AW of `res_data`.
- R2: Any shape with 1 ≤ M ≤ ROWS, 1 ≤ N ≤ COLS and 1 ≤ K ≤ KMAX gives correct results, including non-square shapes and the outer-product case K = 1.
- R3: Operand lanes for rows at or above M and columns at or above N never affect the result, whatever data they carry. Only M rows are presented, and result columns at or above N read as zero.
- R4: The degenerate 1×1×1 job returns the single signed product.
- R5: `op_ready` is high only between an accepted start and the K-th accepted beat. Cycles with `op_valid` low are skipped and add nothing to the result. `op_ready` is low while idle, so operand traffic in that state is ignored.
- R6: `res_valid` and `done` rise together, exactly M+N−2 clock cycles after the edge that accepts the K-th beat. For a 1×1 result they rise on that same edge.
- R7: Result rows come out in ascending order starting at row 0, one per accepted handshake. While `res_ready` is low, the row index and data hold steady.
- R8: A start pulse is ignored unless the block is idle, which is after the last row has drained. A new job's results exclude every earlier job's sums.
- R9: With K = KMAX and every operand at −128, the accumulators do not overflow: each entry equals KMAX·16384.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job; accepted only when idle |
| cfg_m | input | MW | Active rows M (1..ROWS) |
| cfg_n | input | NW | Active columns N (1..COLS) |
| cfg_k | input | KW | Inner length K (1..KMAX) |
| op_valid | input | 1 | Operand beat present |
| op_ready | output | 1 | Block is accepting operand beats |
| a_col | input | ROWS*DW | One column of A, row i at bits i·DW |
| b_row | input | COLS*DW | One row of B, column j at bits j·DW |
| done | output | 1 | All active cells have finished; high until the drain completes |
| res_valid | output | 1 | A result row is presented |
| res_ready | input | 1 | Consumer takes the presented row |
| res_row | output | RW | Index of the presented row |
| res_data | output | COLS*AW | Presented row, column j at bits j·AW |

## Verification
A wrong accumulator or a misaligned skew register shows up only as a wrong entry in a drained row. It therefore appears at the ports M+N−2 cycles after the last beat, at the earliest. The bench compares every active entry of every row, and it fills the unused lanes with noise so that a masking fault also corrupts a visible entry. Faults in the control sequence show sooner. A miscounted beat changes the cycle on which `op_ready` falls. A wrong flush count moves the rise of `res_valid` by one or more cycles, and the bench measures that rise exactly.

// File: rtl/sys_matmul.sv
module sys_matmul #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int KMAX = 8,
  parameter int DW   = 8,
  localparam int AW  = 2*DW + $clog2(KMAX),
  localparam int MW  = $clog2(ROWS+1),
  localparam int NW  = $clog2(COLS+1),
  localparam int KW  = $clog2(KMAX+1),
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [MW-1:0]      cfg_m,
  input  logic [NW-1:0]      cfg_n,
  input  logic [KW-1:0]      cfg_k,
  input  logic               op_valid,
  output logic               op_ready,
  input  logic [ROWS*DW-1:0] a_col,
  input  logic [COLS*DW-1:0] b_row,
  output logic               done,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [RW-1:0]      res_row,
  output logic [COLS*AW-1:0] res_data
);

  localparam int FW = $clog2(ROWS+COLS);

  typedef enum logic [1:0] {S_IDLE, S_FEED, S_FLUSH, S_DRAIN} st_t;
  st_t st;

  logic [MW-1:0] m_q;
  logic [NW-1:0] n_q;
  logic [KW-1:0] k_q;
  logic [KW-1:0] kcnt;
  logic [FW-1:0] fcnt;
  logic [RW-1:0] row_q;

  logic clr, fire;
  assign clr      = (st == S_IDLE) && start;
  assign op_ready = (st == S_FEED);
  assign fire     = op_valid && op_ready;
  assign res_valid = (st == S_DRAIN);
  assign done      = res_valid;
  assign res_row   = row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      m_q   <= '0;
      n_q   <= '0;
      k_q   <= '0;
      kcnt  <= '0;
      fcnt  <= '0;
      row_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          m_q  <= cfg_m;
          n_q  <= cfg_n;
          k_q  <= cfg_k;
          kcnt <= '0;
          st   <= S_FEED;
        end
        S_FEED: if (fire) begin
          if (kcnt == k_q - KW'(1)) begin
            row_q <= '0;
            if (m_q == MW'(1) && n_q == NW'(1)) st <= S_DRAIN;
            else begin
              fcnt <= FW'(m_q) + FW'(n_q) - FW'(2);
              st   <= S_FLUSH;
            end
          end else kcnt <= kcnt + KW'(1);
        end
        S_FLUSH: begin
          if (fcnt == FW'(1)) st <= S_DRAIN;
          else fcnt <= fcnt - FW'(1);
        end
        S_DRAIN: if (res_ready) begin
          if (row_q == RW'(m_q - MW'(1))) st <= S_IDLE;
          else row_q <= row_q + RW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // edge lanes, masked to the active shape
  logic [DW-1:0] ae_d [ROWS];
  logic          ae_v [ROWS];
  logic [DW-1:0] be_d [COLS];

  // operands seen by each cell this cycle
  logic signed [DW-1:0] a_l [ROWS][COLS];
  logic                 v_l [ROWS][COLS];
  logic signed [DW-1:0] b_t [ROWS][COLS];

  logic signed [DW-1:0] a_q [ROWS][COLS];
  logic                 v_q [ROWS][COLS];
  logic signed [DW-1:0] b_q [ROWS][COLS];
  logic signed [AW-1:0] acc [ROWS][COLS];

  for (genvar i = 0; i < ROWS; i++) begin : g_askew
    logic          lv;
    logic [DW-1:0] ld;
    assign lv = fire && (i < int'(m_q));
    assign ld = lv ? a_col[i*DW +: DW] : '0;
    if (i == 0) begin : g_none
      assign ae_v[i] = lv;
      assign ae_d[i] = ld;
    end else begin : g_dly
      logic [DW:0] sr [i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < i; s++) sr[s] <= '0;
        end else begin
          sr[0] <= {lv, ld};
          for (int s = 1; s < i; s++) sr[s] <= sr[s-1];
        end
      end
      assign ae_v[i] = sr[i-1][DW];
      assign ae_d[i] = sr[i-1][DW-1:0];
    end
  end

  for (genvar j = 0; j < COLS; j++) begin : g_bskew
    logic [DW-1:0] ld;
    assign ld = (fire && (j < int'(n_q))) ? b_row[j*DW +: DW] : '0;
    if (j == 0) begin : g_none
      assign be_d[j] = ld;
    end else begin : g_dly
      logic [DW-1:0] sr [j];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < j; s++) sr[s] <= '0;
        end else begin
          sr[0] <= ld;
          for (int s = 1; s < j; s++) sr[s] <= sr[s-1];
        end
      end
      assign be_d[j] = sr[j-1];
    end
  end

  for (genvar i = 0; i < ROWS; i++) begin : g_r
    for (genvar j = 0; j < COLS; j++) begin : g_c
      if (j == 0) begin : g_ledge
        assign a_l[i][j] = ae_d[i];
        assign v_l[i][j] = ae_v[i];
      end else begin : g_lnb
        assign a_l[i][j] = a_q[i][j-1];
        assign v_l[i][j] = v_q[i][j-1];
      end
      if (i == 0) begin : g_tedge
        assign b_t[i][j] = be_d[j];
      end else begin : g_tnb
        assign b_t[i][j] = b_q[i-1][j];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++)
        for (int j = 0; j < COLS; j++) begin
          a_q[i][j] <= '0;
          v_q[i][j] <= 1'b0;
          b_q[i][j] <= '0;
          acc[i][j] <= '0;
        end
    end else begin
      for (int i = 0; i < ROWS; i++)
        for (int j = 0; j < COLS; j++) begin
          a_q[i][j] <= a_l[i][j];
          v_q[i][j] <= v_l[i][j];
          b_q[i][j] <= b_t[i][j];
          if (clr) acc[i][j] <= '0;
          else if (v_l[i][j]) acc[i][j] <= acc[i][j] + a_l[i][j] * b_t[i][j];
        end
    end
  end

  always_comb begin
    for (int j = 0; j < COLS; j++)
      res_data[j*AW +: AW] = (j < int'(n_q)) ? acc[row_q][j] : '0;
  end

endmodule

// File: rtl/sys_matmul_chk.sv
module sys_matmul_chk #(
  parameter int COLS = 4,
  parameter int AW   = 19,
  parameter int NW   = 3,
  parameter int KW   = 4,
  parameter int RW   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_valid,
  input logic               op_ready,
  input logic               done,
  input logic               res_valid,
  input logic               res_ready,
  input logic [RW-1:0]      res_row,
  input logic [COLS*AW-1:0] res_data,
  input logic [NW-1:0]      n_q,
  input logic [KW-1:0]      k_q
);

  logic          rdy_d;
  logic [KW:0]   beats;
  logic          pad_nz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_d <= 1'b0;
      beats <= '0;
    end else begin
      rdy_d <= op_ready;
      if (op_ready && !rdy_d) beats <= (op_valid) ? (KW+1)'(1) : '0;
      else if (op_valid && op_ready) beats <= beats + (KW+1)'(1);
    end
  end

  always_comb begin
    pad_nz = 1'b0;
    for (int j = 0; j < COLS; j++)
      if (j >= int'(n_q) && res_data[j*AW +: AW] != '0) pad_nz = 1'b1;
  end

  AST_FEED_DRAIN_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(op_ready && res_valid)); // R5
  AST_BEAT_COUNT: assert property (@(posedge clk) disable iff (!rst_n) $rose(res_valid) |-> beats == (KW+1)'(k_q)); // R5
  AST_DONE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n) $rose(res_valid) |-> done); // R6
  AST_FIRST_ROW: assert property (@(posedge clk) disable iff (!rst_n) $rose(res_valid) |-> res_row == '0); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) res_valid && !res_ready |=> res_valid && $stable(res_row) && $stable(res_data)); // R7
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n) res_valid && res_ready ##1 res_valid |-> res_row == $past(res_row) + RW'(1)); // R7
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> !pad_nz); // R3

endmodule

bind sys_matmul sys_matmul_chk #(.COLS(COLS), .AW(AW), .NW(NW), .KW(KW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready), .done(done),
  .res_valid(res_valid), .res_ready(res_ready), .res_row(res_row), .res_data(res_data),
  .n_q(n_q), .k_q(k_q)
);

// File: tb/sim_sys_matmul.sv
module sim_sys_matmul;
  localparam int ROWS = 4, COLS = 4, KMAX = 8, DW = 8;
  localparam int AW = 2*DW + $clog2(KMAX);
  localparam int MW = $clog2(ROWS+1), NW = $clog2(COLS+1), KW = $clog2(KMAX+1);
  localparam int RW = $clog2(ROWS);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [MW-1:0] cfg_m = '0;
  logic [NW-1:0] cfg_n = '0;
  logic [KW-1:0] cfg_k = '0;
  logic op_valid = 1'b0, op_ready, done, res_valid, res_ready = 1'b0;
  logic [ROWS*DW-1:0] a_col = '0;
  logic [COLS*DW-1:0] b_row = '0;
  logic [RW-1:0] res_row;
  logic [COLS*AW-1:0] res_data;

  sys_matmul #(.ROWS(ROWS), .COLS(COLS), .KMAX(KMAX), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_k(cfg_k),
    .op_valid(op_valid), .op_ready(op_ready), .a_col(a_col), .b_row(b_row), .done(done),
    .res_valid(res_valid), .res_ready(res_ready), .res_row(res_row), .res_data(res_data));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int unsigned seed = 32'h1234_5678;
  int A [ROWS][KMAX];
  int B [KMAX][COLS];

  function automatic int rnd8();
    seed = seed * 1103515245 + 12345;
    return int'($signed(seed[23:16]));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // mode 0: random, mode 1: all -128
  task automatic run_job(input int m, input int n, input int k, input int mode,
                         input bit gaps, input bit stall, input bit stray, input string tag);
    int lat;
    for (int i = 0; i < ROWS; i++)
      for (int kk = 0; kk < KMAX; kk++) A[i][kk] = (mode == 1) ? -128 : rnd8();
    for (int kk = 0; kk < KMAX; kk++)
      for (int j = 0; j < COLS; j++) B[kk][j] = (mode == 1) ? -128 : rnd8();
    @(negedge clk);
    start = 1'b1; cfg_m = MW'(m); cfg_n = NW'(n); cfg_k = KW'(k);
    @(negedge clk);
    start = 1'b0;
    for (int kk = 0; kk < k; kk++) begin
      if (gaps && kk % 2 == 1) begin
        op_valid = 1'b0; a_col = ROWS*DW'($urandom); b_row = COLS*DW'($urandom);
        @(negedge clk);
      end
      op_valid = 1'b1;
      for (int i = 0; i < ROWS; i++)
        a_col[i*DW +: DW] = (i < m) ? DW'(A[i][kk]) : DW'(rnd8()); // R3 noise lanes
      for (int j = 0; j < COLS; j++)
        b_row[j*DW +: DW] = (j < n) ? DW'(B[kk][j]) : DW'(rnd8());
      if (stray && kk == 0) begin
        start = 1'b1; cfg_m = MW'(1); cfg_n = NW'(1); cfg_k = KW'(1); // R8 ignored
      end
      chk(op_ready == 1'b1, {tag, " R5 ready during feed"}, op_ready, 1);
      @(negedge clk);
      start = 1'b0;
    end
    op_valid = 1'b0;
    chk(op_ready == 1'b0, {tag, " R5 ready drops after K beats"}, op_ready, 0);
    lat = 0;
    while (!res_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == m + n - 2, {tag, " R6 completion latency"}, lat, m + n - 2);
    chk(done == 1'b1, {tag, " R6 done with results"}, done, 1);
    for (int r = 0; r < m; r++) begin
      if (stall && r == 1) begin
        res_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(res_valid && res_row == RW'(r), {tag, " R7 stall holds row"}, int'(res_row), r);
      end
      res_ready = 1'b1;
      chk(res_valid == 1'b1, {tag, " R7 row valid"}, res_valid, 1);
      chk(res_row == RW'(r), {tag, " R7 row order"}, int'(res_row), r);
      for (int j = 0; j < COLS; j++) begin
        logic signed [AW-1:0] g;
        int exp;
        g = res_data[j*AW +: AW];
        exp = 0;
        if (j < n) for (int kk = 0; kk < k; kk++) exp += A[r][kk] * B[kk][j];
        chk(int'(g) == exp, {tag, " R1 entry"}, int'(g), exp);
      end
      @(negedge clk);
    end
    res_ready = 1'b0;
    chk(res_valid == 1'b0 && done == 1'b0, {tag, " R7 drain ends after M rows"}, res_valid, 0);
  endtask

  task automatic t_reset();
    chk(op_ready == 1'b0, "R5 reset ready", op_ready, 0);
    chk(res_valid == 1'b0, "R7 reset valid", res_valid, 0);
    chk(done == 1'b0, "R6 reset done", done, 0);
  endtask

  task automatic t_idle_traffic();
    @(negedge clk);
    op_valid = 1'b1; a_col = '1; b_row = '1;
    @(negedge clk);
    chk(op_ready == 1'b0, "R5 idle ignores beats", op_ready, 0);
    chk(res_valid == 1'b0, "R5 idle no result", res_valid, 0);
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_idle_traffic();
    run_job(4, 4, 8, 0, 0, 0, 0, "full");        // R1
    run_job(2, 3, 5, 0, 0, 0, 0, "nonsquare");   // R2 R3
    run_job(3, 2, 1, 0, 0, 0, 0, "outer");       // R2
    run_job(1, 1, 1, 0, 0, 0, 0, "scalar");      // R4
    run_job(4, 1, 3, 0, 1, 1, 0, "gapstall");    // R5 R7
    run_job(3, 4, 4, 0, 0, 0, 1, "stray");       // R8
    run_job(4, 4, 8, 1, 0, 0, 0, "fullscale");   // R9
    run_job(1, 4, 2, 0, 0, 1, 0, "rowvec");      // R3
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule